// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of several bus masters on a pipelined shared system bus may drive the next address phase. Each master raises its own request line. The arbiter answers with a one-hot grant vector, a binary number for the current owner, and a flag that marks the owner's current sequence as locked.

Grant and ownership move only on rising clock edges where the bus-ready input is high. On such an edge the master that held the grant becomes the owner, and a new grant is chosen. Two policies are available, picked by a static input:

- **Fixed priority:** the highest-numbered eligible requester wins.
- **Round robin:** the search starts at the master after the current grant holder and wraps around.

The arbiter also handles three special cases:

- **Lock:** a granted master that holds its lock line keeps the grant.
- **Split:** a master that receives a split response is removed from arbitration until the matching bit of the 16-bit release vector clears it.
- **Idle:** with no eligible request, the grant parks on master 0.

A three-state machine tracks the bus:

- PARK: nothing is being served.
- BUSY: a requester holds the grant.
- HOLD: a locked sequence keeps its owner.

On every ready edge the next state is chosen in this order:

1. HOLD if the granted master holds its lock line.
2. Otherwise BUSY if any eligible request exists.
3. Otherwise PARK.

With the bus not ready the state does not change. The policy input is copied into the active policy only while the state is PARK.

Top module: `ahb_bus_arbiter`

## Requirements
- R1: Out of reset, grant is 8'h01 (master 0), owner_id is 0 and owner_locked is 0.
- R2: Exactly one bit of grant is set in every cycle.
- R3: On an edge where xfer_ready is low, grant, owner_id and owner_locked keep their values.
- R4: On an edge where xfer_ready is high, owner_id takes the index of the master that held the grant before the edge. On the same edge, owner_locked takes that master's lock_req bit.
- R5: With the fixed-priority policy active, a ready edge grants the eligible requester with the highest index (master 7 beats all others).
- R6: With the round-robin policy active, a ready edge grants the first eligible requester met when searching upward from the index after the current grant, wrapping from 7 to 0.
- R7: A ready edge with no eligible request (and no lock held by the granted master) parks the grant on master 0.
- R8: If the granted master's lock_req bit is high on a ready edge, the grant stays on that master whatever the other requests are.
- R9: split_resp high on a ready edge masks the master named by owner_id. A masked master's bus_req is ignored by arbitration.
- R10: A set bit i of split_release, for i below 8, clears the mask of master i. Bits 8 to 15 have no effect.
- R11: policy_rr (0 = fixed priority, 1 = round robin) is captured only on edges where the state is PARK. A change while masters are being served has no effect until the bus goes idle.
- R12: In round-robin mode, with all eight masters requesting continuously, no locks and the bus always ready, every master is granted within 8 consecutive ready edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_rr | input | 1 | Policy select: 0 fixed priority, 1 round robin (captured in PARK) |
| xfer_ready | input | 1 | Bus ready; ownership moves only on edges where it is high |
| bus_req | input | 8 | Per-master bus request |
| lock_req | input | 8 | Per-master locked-sequence request |
| split_resp | input | 1 | Current owner received a split response |
| split_release | input | 16 | Per-master split release; bits at and above 8 are unused |
| grant | output | 8 | One-hot grant |
| owner_id | output | 4 | Index of the master owning the address phase |
| owner_locked | output | 1 | Owner's current sequence is locked |

## Verification
The hardest situation to reach is a masked master whose request must be ignored. To get there, the stimulus first makes the target master the owner by granting it and letting a ready edge pass. It then raises split_resp on a ready edge, and afterwards requests only from that master, so a correct design must park.

A release on an unused high bit of split_release follows, and must leave the mask in place. Only the matching low bit may restore the grant.

A mode change while masters are busy is a second hard case. It is reached by holding all requests high, toggling the policy, and seeing that the grant keeps following fixed priority until the requests drop and the bus parks.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic [N-1:0]   cand,
    output logic           found,
    output logic [IDW-1:0] idx
);
    // Highest index wins: the last match in an ascending scan.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (cand[k]) begin
                found = 1'b1;
                idx   = IDW'(k);
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic [N-1:0]   cand,
    input  logic [IDW-1:0] start,
    output logic           found,
    output logic [IDW-1:0] idx
);
    // Circular search from start; the nearest match is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = int'(start) + k;
            if (pos >= N) pos = pos - N;
            if (cand[pos]) begin
                found = 1'b1;
                idx   = IDW'(pos);
            end
        end
    end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
    parameter int N       = 8,
    parameter int IDW     = 3,
    parameter int SPLIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDW-1:0]     set_idx,
    input  logic [SPLIT_W-1:0] release_vec,
    output logic [N-1:0]       mask
);
    logic [N-1:0] mask_q;
    logic         unused_rel;

    // Upper release bits name no master.
    assign unused_rel = ^release_vec;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else begin
                mask_q[i] <= (mask_q[i] & ~release_vec[i]) |
                             (set_en && (set_idx == IDW'(i)));
            end
        end
    end

    assign mask = mask_q;
endmodule

// File: rtl/ahb_bus_arbiter.sv
module ahb_bus_arbiter
    import ahb_arb_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int OWNER_W   = 4,
    parameter int SPLIT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 policy_rr,
    input  logic                 xfer_ready,
    input  logic [N_MASTERS-1:0] bus_req,
    input  logic [N_MASTERS-1:0] lock_req,
    input  logic                 split_resp,
    input  logic [SPLIT_W-1:0]   split_release,
    output logic [N_MASTERS-1:0] grant,
    output logic [OWNER_W-1:0]   owner_id,
    output logic                 owner_locked
);
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    arb_state_e     state_q, state_d;
    logic [IDW-1:0] grant_q, grant_d;
    logic [IDW-1:0] owner_q;
    logic           olock_q;
    logic           mode_q, mode_d;

    logic [N_MASTERS-1:0] mask_vec;
    logic [N_MASTERS-1:0] eligible;
    logic [IDW-1:0]       rr_start;
    logic                 prio_found, rr_found;
    logic [IDW-1:0]       prio_idx, rr_idx;
    logic                 lock_keep;

    arb_split_mask #(
        .N(N_MASTERS), .IDW(IDW), .SPLIT_W(SPLIT_W)
    ) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (split_resp & xfer_ready),
        .set_idx     (owner_q),
        .release_vec (split_release),
        .mask        (mask_vec)
    );

    assign eligible  = bus_req & ~mask_vec;
    assign lock_keep = lock_req[grant_q];

    always_comb begin
        if (int'(grant_q) + 1 >= N_MASTERS) rr_start = '0;
        else                                rr_start = grant_q + IDW'(1);
    end

    arb_prio_pick #(.N(N_MASTERS), .IDW(IDW)) u_prio (
        .cand  (eligible),
        .found (prio_found),
        .idx   (prio_idx)
    );

    arb_rr_pick #(.N(N_MASTERS), .IDW(IDW)) u_rr (
        .cand  (eligible),
        .start (rr_start),
        .found (rr_found),
        .idx   (rr_idx)
    );

    // Next-state and next-grant decision.
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_PARK: mode_d = policy_rr;
            ST_BUSY: mode_d = mode_q;
            ST_HOLD: mode_d = mode_q;
            default: mode_d = mode_q;
        endcase
        if (xfer_ready) begin
            if (lock_keep) begin
                state_d = ST_HOLD;
                grant_d = grant_q;
            end else if (mode_q ? rr_found : prio_found) begin
                state_d = ST_BUSY;
                grant_d = mode_q ? rr_idx : prio_idx;
            end else begin
                state_d = ST_PARK;
                grant_d = '0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            grant_q <= '0;
            owner_q <= '0;
            olock_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            mode_q  <= mode_d;
            if (xfer_ready) begin
                owner_q <= grant_q;
                olock_q <= lock_keep;
            end
        end
    end

    // Outputs.
    always_comb begin
        grant        = '0;
        grant[grant_q] = 1'b1;
        owner_id     = OWNER_W'(owner_q);
        owner_locked = olock_q;
    end
endmodule

// File: rtl/ahb_arb_checker.sv
module ahb_arb_checker #(
    parameter int N_MASTERS = 8,
    parameter int OWNER_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xfer_ready,
    input logic [N_MASTERS-1:0] bus_req,
    input logic [N_MASTERS-1:0] lock_req,
    input logic [N_MASTERS-1:0] grant,
    input logic [OWNER_W-1:0]   owner_id,
    input logic                 owner_locked
);
    logic [OWNER_W-1:0] gidx;

    always_comb begin
        gidx = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (grant[i]) gidx = OWNER_W'(i);
        end
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grant));

    assert_hold_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ready |=> $stable(grant) && $stable(owner_id) && $stable(owner_locked));

    assert_owner_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ready |=> (owner_id == $past(gidx)) &&
                       (owner_locked == $past(|(lock_req & grant))));

    assert_park_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && (bus_req == '0) && ((lock_req & grant) == '0))
            |=> grant == N_MASTERS'(1));

    assert_lock_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && ((lock_req & grant) != '0)) |=> $stable(grant));
endmodule

bind ahb_bus_arbiter ahb_arb_checker #(
    .N_MASTERS (N_MASTERS),
    .OWNER_W   (OWNER_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_ready   (xfer_ready),
    .bus_req      (bus_req),
    .lock_req     (lock_req),
    .grant        (grant),
    .owner_id     (owner_id),
    .owner_locked (owner_locked)
);

// File: tb/tb_ahb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_ahb_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        policy_rr;
    logic        xfer_ready;
    logic [7:0]  bus_req;
    logic [7:0]  lock_req;
    logic        split_resp;
    logic [15:0] split_release;
    logic [7:0]  grant;
    logic [3:0]  owner_id;
    logic        owner_locked;

    int total = 0;
    int bad   = 0;

    // Reference model state.
    int       m_g, m_own, m_st;
    bit       m_olock, m_mode;
    bit [7:0] m_mask;

    always #5 clk = ~clk;

    ahb_bus_arbiter dut (
        .clk(clk), .rst_n(rst_n), .policy_rr(policy_rr), .xfer_ready(xfer_ready),
        .bus_req(bus_req), .lock_req(lock_req), .split_resp(split_resp),
        .split_release(split_release), .grant(grant), .owner_id(owner_id),
        .owner_locked(owner_locked)
    );

    function automatic int prio_ref(bit [7:0] e);
        for (int i = 7; i >= 0; i--) if (e[i]) return i;
        return 0;
    endfunction

    function automatic int rr_ref(bit [7:0] e, int g);
        for (int k = 1; k <= 8; k++) if (e[(g + k) % 8]) return (g + k) % 8;
        return 0;
    endfunction

    task automatic model_edge();
        int old_g, old_own, old_st;
        bit [7:0] e;
        old_g = m_g; old_own = m_own; old_st = m_st;
        e = bus_req & ~m_mask;
        if (xfer_ready) begin
            if (lock_req[old_g]) begin
                m_g = old_g; m_st = 2;
            end else if (e == 8'h00) begin
                m_g = 0; m_st = 0;
            end else begin
                m_g = m_mode ? rr_ref(e, old_g) : prio_ref(e);
                m_st = 1;
            end
            m_own = old_g;
            m_olock = lock_req[old_g];
        end
        m_mask = (m_mask & ~split_release[7:0]) |
                 ((split_resp && xfer_ready) ? (8'h01 << old_own) : 8'h00);
        if (old_st == 0) m_mode = policy_rr;
    endtask

    task automatic check(string tag, bit ok, string act, string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        bit [7:0] eg;
        eg = 8'h01 << m_g;
        check(tag, grant == eg && owner_id == 4'(m_own) && owner_locked == m_olock,
              $sformatf("g=%h o=%0d l=%0d", grant, owner_id, owner_locked),
              $sformatf("g=%h o=%0d l=%0d", eg, m_own, m_olock));
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        bus_req = 8'h00; lock_req = 8'h00; split_resp = 1'b0;
        split_release = 16'h0000; xfer_ready = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        bit [7:0]  seen;
        rst_n = 1'b0; policy_rr = 1'b0;
        idle_inputs();
        m_g = 0; m_own = 0; m_st = 0; m_olock = 0; m_mode = 0; m_mask = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 explicit reset values
        check("R1", grant == 8'h01 && owner_id == 4'd0 && owner_locked == 1'b0,
              $sformatf("%h/%0d/%0d", grant, owner_id, owner_locked), "01/0/0");
        compare("R1");

        // R5 and R7: every request pattern under fixed priority, each from park
        for (int p = 1; p < 256; p++) begin
            bus_req = 8'(p);
            step("R5");
            check("R5", grant == (8'h01 << prio_ref(8'(p))),
                  $sformatf("%h", grant), $sformatf("%h", 8'h01 << prio_ref(8'(p))));
            bus_req = 8'h00;
            step("R7");
        end

        // R11: policy change while busy is ignored
        bus_req = 8'hFF;
        step("R11");
        policy_rr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step("R11");
            check("R11", grant == 8'h80, $sformatf("%h", grant), "80");
        end
        bus_req = 8'h00;
        step("R11");
        step("R11");

        // R6 and R12: round robin with all requesting
        bus_req = 8'hFF;
        seen = 8'h00;
        for (int i = 0; i < 8; i++) begin
            step("R6");
            seen |= grant;
        end
        check("R12", seen == 8'hFF, $sformatf("%h", seen), "ff");
        bus_req = 8'h24;
        for (int i = 0; i < 4; i++) step("R6");

        // R3: not ready holds everything
        xfer_ready = 1'b0;
        bus_req = 8'h81; lock_req = 8'hFF;
        for (int i = 0; i < 3; i++) step("R3");
        xfer_ready = 1'b1; lock_req = 8'h00;
        step("R3");

        // R8 and R4: lock retention and lock flag
        bus_req = 8'h08;
        step("R8");
        lock_req = 8'h08; bus_req = 8'hF7;
        for (int i = 0; i < 3; i++) begin
            step("R8");
            check("R8", grant == 8'h08, $sformatf("%h", grant), "08");
        end
        check("R4", owner_locked == 1'b1 && owner_id == 4'd3,
              $sformatf("%0d/%0d", owner_id, owner_locked), "3/1");
        lock_req = 8'h00; bus_req = 8'h00;
        step("R4"); step("R4");

        // R9 and R10: split masking and release
        bus_req = 8'h20;
        step("R9"); step("R9");
        split_resp = 1'b1;
        step("R9");
        split_resp = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step("R9");
            check("R9", grant == 8'h01, $sformatf("%h", grant), "01");
        end
        split_release = 16'h2000;
        step("R10");
        split_release = 16'h0000;
        step("R10");
        check("R10", grant == 8'h01, $sformatf("%h", grant), "01");
        split_release = 16'h0020;
        step("R10");
        split_release = 16'h0000;
        step("R10");
        check("R10", grant == 8'h20, $sformatf("%h", grant), "20");

        // R4: long pseudo-random run against the model
        lf = 32'h1234_5679;
        for (int i = 0; i < 3000; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            bus_req       = lf[7:0];
            xfer_ready    = lf[9:8] != 2'b00;
            lock_req      = (lf[12:10] == 3'b000) ? lf[20:13] : 8'h00;
            split_resp    = lf[25:21] == 5'd0;
            split_release = (lf[28:26] == 3'd0) ? {lf[7:0], lf[15:8]} : 16'h0000;
            policy_rr     = lf[30];
            step("R4");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule